// File: doc/BRIEF.md
# System Reset Sequencer with Shared Open-Drain Reset Line

This block decides when the rest of the chip is held in reset and for how long. It gathers reset requests from several places: a board-level reset line that is shared with other devices, power-on, brown-out, the watchdog, a software-written register bit, an illegal-state fault detector and wake-up from stop mode. Once a request is accepted, the block holds the core in reset for a configurable number of system clock cycles. It also pulls the shared line low, open-drain style, so that every device on that line is reset along with the chip. The cause of the most recent reset is kept in a small status register that software reads and clears.

The shared line works in both directions. The block sees the line as the wired-AND of the outside drivers and its own pull-down. It only counts the line as a reset request after the line has been low for a run of consecutive clock samples, unless the chip is in stop mode, where a single low sample is enough. The end of a reset depends on the line. If the outside world lets go during the time-out, the block goes on pulling the line low until the time-out ends. If the line is still held low when the time-out ends, the core stays in reset until a fixed tail of cycles after the line is released. A reset caused by waking from stop mode counts ticks of the internal oscillator instead of system clocks, and it leaves the line alone.

All interfaces are plain control and status pins, sampled on the rising clock edge. No stream interface is involved, so there is no valid/ready handshake and no back-pressure. The register port accepts a write in any cycle.

Top module: `sysrst_sequencer`

## Requirements
- R1: In the idle state, with stop_mode low, the line starts a reset only when pin_in is sampled low on FILT_CYC (default 4) consecutive clock edges. A low pulse of FILT_CYC-1 samples or fewer leaves core_rst_n at 1.
- R2: A brown-out, watchdog, fault or software request sampled on edge e drives pin_oe to 1 and core_rst_n to 0 right after e. pin_oe stays at 1 for exactly TIMEOUT_CYC cycles. If the line then reads high, core_rst_n returns to 1 one cycle after pin_oe falls.
- R3: If pin_in is still low in the cycle after pin_oe falls, core_rst_n stays at 0 while the line is low. It rises on the TAIL_CYC-th (default 16) clock edge that samples the line high.
- R4: A line-started reset whose outside driver lets go before the time-out still holds pin_oe at 1 for the full TIMEOUT_CYC cycles, counted from the edge that accepted the request.
- R5: A register write with reg_wdata[0]=1 starts a reset. dbg_rst_n follows core_rst_n, except that it stays at 1 for a software reset whose write had reg_from_dbg=1.
- R6: Status bits in reg_rdata: [7] power-on, [6] line, [5] watchdog, [4] brown-out, [3] software, [2] fault, [1] stop wake-up; bit 0 always reads 0. An accepted reset sets only its own bit and clears the others. Writing 1 to bits 7..1 clears them, and writing 0 leaves them unchanged.
- R7: A request accepted while a reset is already running restarts the time-out, so pin_oe stays at 1 for TIMEOUT_CYC cycles after the later request.
- R8: stop_wake in the idle state holds core_rst_n at 0 until STOP_TICKS (default 66) osc_tick pulses have been sampled, with pin_oe at 0 throughout. With stop_mode high in the idle state, a single low sample of pin_in starts a reset.
- R9: When several requests arrive on the same edge, the recorded cause follows the priority fault > watchdog > brown-out > software > line > stop wake-up.
- R10: While por_n is low, core_rst_n=0, pin_oe=1 and reg_rdata=0x80. After por_n is released, pin_oe stays at 1 for TIMEOUT_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | 1 | Synchronised, analog-filtered level of the shared reset line |
| pin_oe | output | 1 | 1 pulls the shared line low |
| brownout_evt | input | 1 | Brown-out request, one-cycle pulse |
| wdog_evt | input | 1 | Watchdog request, one-cycle pulse |
| fault_evt | input | 1 | Illegal-state fault request, one-cycle pulse |
| stop_mode | input | 1 | Chip is in stop mode (pin filter bypassed) |
| stop_wake | input | 1 | Stop-mode wake-up request, one-cycle pulse |
| osc_tick | input | 1 | One pulse per internal oscillator period |
| reg_wr | input | 1 | Write strobe for the reset control/status register |
| reg_from_dbg | input | 1 | The write comes from the debug port |
| reg_wdata | input | 8 | Write data: bit 0 starts a reset, bits 7..1 clear status |
| reg_rdata | output | 8 | Reset cause status |
| core_rst_n | output | 1 | Core reset, active low |
| dbg_rst_n | output | 1 | Debug logic reset, active low |

## Verification
A request sampled on a clock edge shows up on pin_oe, core_rst_n and reg_rdata right after that same edge. The line filter needs its FILT_CYC-th low sample. After the time-out, core_rst_n rises one edge after pin_oe falls, or else on the TAIL_CYC-th edge that samples the line high. The bench keeps a reference model in integers and updates it on the same rising edge the design uses. It drives inputs and compares all outputs at the falling edge, so every result is checked in the cycle it first becomes due. Directed checks count falling edges with pin_oe high, edges from line release to core release, and oscillator ticks up to release, and compare each count against the parameter it should equal.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_SAMPLE,
    ST_WAIT,
    ST_TAIL,
    ST_STOP
  } seq_state_e;

  localparam int STAT_W = 8;
  localparam int B_POR  = 7;
  localparam int B_EXT  = 6;
  localparam int B_WDT  = 5;
  localparam int B_BO   = 4;
  localparam int B_SW   = 3;
  localparam int B_FLT  = 2;
  localparam int B_STOP = 1;

  // sources in falling priority order
  localparam int NSRC = 5;
  localparam int SRC_POS [NSRC] = '{B_FLT, B_WDT, B_BO, B_SW, B_EXT};

  typedef struct packed {
    logic              start;
    logic              stop;
    logic              dbg_keep;
    logic [STAT_W-1:0] flag;
  } rst_req_t;
endpackage

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bypass,
  input  logic pin_in,
  output logic ext_req
);
  localparam int FW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [FW-1:0] F_LAST = FW'(FILT_LEN - 1);

  logic [FW-1:0] low_cnt;

  assign ext_req = enable && !pin_in && (bypass || (low_cnt == F_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           low_cnt <= '0;
    else if (!enable || pin_in || ext_req) low_cnt <= '0;
    else                                  low_cnt <= low_cnt + 1'b1;
  end

  AST_RUN_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (low_cnt != '0) |-> $past(!pin_in && enable)); // R1
  AST_FILTER_REQ_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req && !bypass && FILT_LEN > 1) |-> $past(!pin_in)); // R1
endmodule

// File: rtl/sysrst_cause_arb.sv
module sysrst_cause_arb
  import sysrst_pkg::*;
(
  input  logic     fault_i,
  input  logic     wdog_i,
  input  logic     brown_i,
  input  logic     sw_i,
  input  logic     sw_dbg_i,
  input  logic     ext_i,
  input  logic     stop_i,
  output rst_req_t req_o
);
  logic [NSRC-1:0] src;
  assign src = {ext_i, sw_i, brown_i, wdog_i, fault_i};

  always_comb begin
    req_o       = '0;
    req_o.start = |src;
    for (int i = 0; i < NSRC; i++) begin
      if (src[i] && (req_o.flag == '0)) req_o.flag[SRC_POS[i]] = 1'b1;
    end
    if (!req_o.start && stop_i) begin
      req_o.stop         = 1'b1;
      req_o.flag[B_STOP] = 1'b1;
    end
    req_o.dbg_keep = sw_i && sw_dbg_i && (src[2:0] == '0);
  end
endmodule

// File: rtl/sysrst_seq_fsm.sv
module sysrst_seq_fsm
  import sysrst_pkg::*;
#(
  parameter int TIMEOUT    = 256,
  parameter int TAIL_LEN   = 16,
  parameter int STOP_TICKS = 66
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stop_start,
  input  logic       pin_in,
  input  logic       osc_tick,
  output seq_state_e state
);
  localparam int MAXC = (TIMEOUT > STOP_TICKS) ?
                        ((TIMEOUT > TAIL_LEN) ? TIMEOUT : TAIL_LEN) :
                        ((STOP_TICKS > TAIL_LEN) ? STOP_TICKS : TAIL_LEN);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RUN_LAST  = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_LEN - 1);
  localparam logic [CW-1:0] STOP_LAST = CW'(STOP_TICKS - 1);

  logic [CW-1:0] cnt, cnt_nx;
  seq_state_e    state_nx;

  always_comb begin
    state_nx = state;
    cnt_nx   = cnt;
    if (start) begin
      state_nx = ST_RUN;
      cnt_nx   = '0;
    end else if (stop_start) begin
      state_nx = ST_STOP;
      cnt_nx   = '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (cnt == RUN_LAST) begin
            state_nx = ST_SAMPLE;
            cnt_nx   = '0;
          end else cnt_nx = cnt + 1'b1;
        end
        ST_SAMPLE: state_nx = pin_in ? ST_IDLE : ST_WAIT;
        ST_WAIT: begin
          if (pin_in) begin
            state_nx = ST_TAIL;
            cnt_nx   = CW'(1);
          end
        end
        ST_TAIL: begin
          if (cnt == TAIL_LAST) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
          end else cnt_nx = cnt + 1'b1;
        end
        ST_STOP: begin
          if (osc_tick) begin
            if (cnt == STOP_LAST) begin
              state_nx = ST_IDLE;
              cnt_nx   = '0;
            end else cnt_nx = cnt + 1'b1;
          end
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  AST_RESTART_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_RUN && cnt == '0)); // R7
  AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && cnt == RUN_LAST && !start) |=> (state == ST_SAMPLE)); // R2
  AST_WAIT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !pin_in && !start) |=> (state == ST_WAIT)); // R3
  AST_TAIL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL && cnt == TAIL_LAST && !start) |=> (state == ST_IDLE)); // R3
  AST_STOP_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && !osc_tick && !start) |=> (state == ST_STOP)); // R8
endmodule

// File: rtl/sysrst_status_reg.sv
module sysrst_status_reg
  import sysrst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_valid,
  input  logic [STAT_W-1:0] set_flags,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] rdata
);
  logic [STAT_W-1:0] flags;
  localparam logic [STAT_W-1:0] POR_VAL = STAT_W'(1) << B_POR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags <= POR_VAL;
    else if (set_valid) flags <= set_flags;
    else if (wr)        flags <= flags & ~{wdata[STAT_W-1:1], 1'b0};
  end

  assign rdata = flags;

  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid |=> ($countones(rdata) == 1)); // R6
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rdata[0] == 1'b0)); // R6
endmodule

// File: rtl/sysrst_sequencer.sv
module sysrst_sequencer
  import sysrst_pkg::*;
#(
  parameter int TIMEOUT_CYC = 256,
  parameter int TAIL_CYC    = 16,
  parameter int FILT_CYC    = 4,
  parameter int STOP_TICKS  = 66
) (
  input  logic              clk_sys,
  input  logic              por_n,
  input  logic              pin_in,
  output logic              pin_oe,
  input  logic              brownout_evt,
  input  logic              wdog_evt,
  input  logic              fault_evt,
  input  logic              stop_mode,
  input  logic              stop_wake,
  input  logic              osc_tick,
  input  logic              reg_wr,
  input  logic              reg_from_dbg,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic              core_rst_n,
  output logic              dbg_rst_n
);
  seq_state_e state;
  rst_req_t   req;
  logic       ext_req;
  logic       filt_en;
  logic       dbg_keep;
  logic       sw_req;

  assign filt_en = (state == ST_IDLE) || (state == ST_TAIL);
  assign sw_req  = reg_wr && reg_wdata[0];

  sysrst_pin_filter #(.FILT_LEN(FILT_CYC)) u_filter (
    .clk     (clk_sys),
    .rst_n   (por_n),
    .enable  (filt_en),
    .bypass  (stop_mode && (state == ST_IDLE)),
    .pin_in  (pin_in),
    .ext_req (ext_req)
  );

  sysrst_cause_arb u_arb (
    .fault_i  (fault_evt),
    .wdog_i   (wdog_evt),
    .brown_i  (brownout_evt),
    .sw_i     (sw_req),
    .sw_dbg_i (reg_from_dbg),
    .ext_i    (ext_req),
    .stop_i   (stop_wake && (state == ST_IDLE)),
    .req_o    (req)
  );

  sysrst_seq_fsm #(
    .TIMEOUT    (TIMEOUT_CYC),
    .TAIL_LEN   (TAIL_CYC),
    .STOP_TICKS (STOP_TICKS)
  ) u_fsm (
    .clk        (clk_sys),
    .rst_n      (por_n),
    .start      (req.start),
    .stop_start (req.stop),
    .pin_in     (pin_in),
    .osc_tick   (osc_tick),
    .state      (state)
  );

  sysrst_status_reg u_status (
    .clk       (clk_sys),
    .rst_n     (por_n),
    .set_valid (req.start || req.stop),
    .set_flags (req.flag),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata)
  );

  always_ff @(posedge clk_sys or negedge por_n) begin
    if (!por_n)                     dbg_keep <= 1'b0;
    else if (req.start || req.stop) dbg_keep <= req.dbg_keep;
  end

  assign pin_oe     = (state == ST_RUN);
  assign core_rst_n = (state == ST_IDLE);
  assign dbg_rst_n  = core_rst_n || dbg_keep;

  AST_DRIVE_ON_REQUEST: assert property (@(posedge clk_sys) disable iff (!por_n)
    req.start |=> (pin_oe && !core_rst_n)); // R2
  AST_DEBUG_SPARED: assert property (@(posedge clk_sys) disable iff (!por_n)
    (sw_req && reg_from_dbg && !fault_evt && !wdog_evt && !brownout_evt) |=> dbg_rst_n); // R5
endmodule

// File: tb/sysrst_sequencer_test.sv
module sysrst_sequencer_test;
  localparam int T  = 64;
  localparam int TL = 16;
  localparam int FL = 4;
  localparam int ST = 66;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_low = 1'b0;
  logic       pin_oe;
  logic       bo = 1'b0, wd = 1'b0, ft = 1'b0;
  logic       stop_mode = 1'b0, stop_wake = 1'b0, osc_tick = 1'b0;
  logic       reg_wr = 1'b0, reg_dbg = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       core_rst_n, dbg_rst_n;
  wire        pin_line = !(ext_low || pin_oe);

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  sysrst_sequencer #(.TIMEOUT_CYC(T), .TAIL_CYC(TL), .FILT_CYC(FL), .STOP_TICKS(ST)) uut (
    .clk_sys(clk), .por_n(por_n), .pin_in(pin_line), .pin_oe(pin_oe),
    .brownout_evt(bo), .wdog_evt(wd), .fault_evt(ft),
    .stop_mode(stop_mode), .stop_wake(stop_wake), .osc_tick(osc_tick),
    .reg_wr(reg_wr), .reg_from_dbg(reg_dbg), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .core_rst_n(core_rst_n), .dbg_rst_n(dbg_rst_n));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: ph 0 idle, 1 driving, 2 sample, 3 wait, 4 tail, 5 stop
  int m_ph = 1, m_rem = T, m_tc = 0, m_sc = 0, m_low = 0;
  logic [7:0] m_st = 8'h80;
  bit m_keep = 1'b0;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ph = 1; m_rem = T; m_low = 0; m_st = 8'h80; m_keep = 1'b0;
    end else begin
      automatic bit pin  = pin_line;
      automatic bit sw   = reg_wr && reg_wdata[0];
      automatic bit fon  = (m_ph == 0) || (m_ph == 4);
      automatic bit ext  = 1'b0;
      automatic int c    = -1;
      if (fon && !pin && ((m_ph == 0 && stop_mode) || m_low == FL - 1)) ext = 1'b1;
      if (fon && !pin && !ext) m_low++; else m_low = 0;
      if (ft) c = 2; else if (wd) c = 5; else if (bo) c = 4;
      else if (sw) c = 3; else if (ext) c = 6;
      else if (m_ph == 0 && stop_wake) c = 1;
      if (c > 1) begin
        m_ph = 1; m_rem = T; m_st = 8'(1 << c); m_keep = (c == 3) && reg_dbg;
      end else if (c == 1) begin
        m_ph = 5; m_sc = 0; m_st = 8'h02; m_keep = 1'b0;
      end else begin
        if (reg_wr) m_st = m_st & ~{reg_wdata[7:1], 1'b0};
        case (m_ph)
          1: if (m_rem == 1) m_ph = 2; else m_rem--;
          2: m_ph = pin ? 0 : 3;
          3: if (pin) begin m_ph = 4; m_tc = 1; end
          4: if (m_tc == TL - 1) m_ph = 0; else m_tc++;
          5: if (osc_tick) begin if (m_sc == ST - 1) m_ph = 0; else m_sc++; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk({cur_req, " pin_oe"}, pin_oe, m_ph == 1);
      chk({cur_req, " core_rst_n"}, core_rst_n, m_ph == 0);
      chk({cur_req, " dbg_rst_n"}, dbg_rst_n, (m_ph == 0) || m_keep);
      chk({cur_req, " reg_rdata"}, reg_rdata, m_st);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 2000 && !core_rst_n; g++) @(negedge clk);
  endtask

  task automatic measure_oe(output int n);
    n = 0;
    for (int g = 0; g < 2000 && !pin_oe; g++) @(negedge clk);
    while (pin_oe && n < 5000) begin n++; @(negedge clk); end
  endtask

  // mask bits: 0 brown-out, 1 watchdog, 2 fault
  task automatic pulse(input int mask);
    @(negedge clk);
    bo = mask[0]; wd = mask[1]; ft = mask[2];
    @(negedge clk);
    bo = 1'b0; wd = 1'b0; ft = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] d, input logic dbg);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d; reg_dbg = dbg;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00; reg_dbg = 1'b0;
  endtask

  task automatic ext_pulse(input int n);
    @(negedge clk);
    ext_low = 1'b1;
    tick(n);
    ext_low = 1'b0;
  endtask

  initial begin
    int n;
    // R10: power-on state and the sequence after release
    tick(3);
    chk("R10 core_rst_n during por", core_rst_n, 0);
    chk("R10 pin_oe during por", pin_oe, 1);
    chk("R10 rdata during por", reg_rdata, 8'h80);
    por_n = 1'b1;
    measure_oe(n);
    chk("R10 drive length after por", n, T);
    tick(1);
    chk("R10 core released after por", core_rst_n, 1);

    // R1: short pulse rejected, long pulse accepted
    cur_req = "R1";
    ext_pulse(FL - 1);
    tick(3);
    chk("R1 short pulse ignored", core_rst_n, 1);
    ext_pulse(FL);
    @(negedge clk);
    chk("R1 long pulse starts reset", core_rst_n, 0);
    chk("R6 line cause flag", reg_rdata, 8'h40);

    // R4: driver released early, drive lasts full time-out
    cur_req = "R4";
    measure_oe(n);
    chk("R4 drive length after early release", n, T - 1);
    wait_idle();

    cur_req = "R4";
    ext_pulse(FL + 5);
    wait_idle();
    tick(2);

    // R3: line held past time-out, tail after release
    cur_req = "R3";
    @(negedge clk);
    ext_low = 1'b1;
    tick(T + 40);
    chk("R3 core held while line low", core_rst_n, 0);
    ext_low = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!core_rst_n && n < 200);
    chk("R3 edges from release to core release", n, TL);

    // R2: internal source timing
    cur_req = "R2";
    pulse(1);
    chk("R2 pin driven after brown-out", pin_oe, 1);
    chk("R6 brown-out flag", reg_rdata, 8'h10);
    measure_oe(n);
    chk("R2 drive length brown-out", n - 1, T - 1);
    chk("R2 core still held as drive ends", core_rst_n, 0);
    tick(1);
    chk("R2 core released one cycle later", core_rst_n, 1);

    // R6: write-one-to-clear
    cur_req = "R6";
    wr_reg(8'h40, 1'b0);
    chk("R6 write to other bit ignored", reg_rdata, 8'h10);
    wr_reg(8'h10, 1'b0);
    chk("R6 write one clears", reg_rdata, 8'h00);

    // R5: software reset from CPU and debug
    cur_req = "R5";
    wr_reg(8'h01, 1'b0);
    chk("R5 cpu software reset core", core_rst_n, 0);
    chk("R5 cpu software reset debug", dbg_rst_n, 0);
    chk("R6 software flag", reg_rdata, 8'h08);
    wait_idle();
    wr_reg(8'h01, 1'b1);
    chk("R5 debug write resets core", core_rst_n, 0);
    chk("R5 debug logic spared", dbg_rst_n, 1);
    wait_idle();

    // R7: restart while running
    cur_req = "R7";
    pulse(2);
    tick(10);
    pulse(4);
    measure_oe(n);
    chk("R7 restarted drive length", n, T);
    chk("R7 cause after restart", reg_rdata, 8'h04);
    wait_idle();

    // R9: priority
    cur_req = "R9";
    pulse(7);
    chk("R9 fault wins", reg_rdata, 8'h04);
    wait_idle();
    @(negedge clk);
    bo = 1'b1; wd = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h01;
    @(negedge clk);
    bo = 1'b0; wd = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    chk("R9 watchdog over brown-out and software", reg_rdata, 8'h20);
    wait_idle();

    // R8: stop wake-up counted in oscillator ticks
    cur_req = "R8";
    @(negedge clk);
    stop_wake = 1'b1;
    @(negedge clk);
    stop_wake = 1'b0;
    chk("R8 core held on wake-up", core_rst_n, 0);
    chk("R6 stop flag", reg_rdata, 8'h02);
    n = 0;
    for (int i = 0; i < 400 && !core_rst_n; i++) begin
      if (pin_oe) chk("R8 line not driven in wake-up", pin_oe, 0);
      osc_tick = (i % 3 == 0);
      if (osc_tick) n++;
      @(negedge clk);
      osc_tick = 1'b0;
    end
    chk("R8 ticks until release", n, ST);
    stop_mode = 1'b1;
    ext_pulse(1);
    @(negedge clk);
    chk("R8 stop mode single low sample", core_rst_n, 0);
    stop_mode = 1'b0;
    wait_idle();
    tick(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule